// File: doc/BRIEF.md
# Low-Power Mode Controller

This block steps a microcontroller through four power modes, picked by a 2-bit mode field that software writes over a register bus. For each mode it drives the gating enables: the CPU clock, the power domain of the general peripherals, and the always-on domain that holds GPIO and the system controller. It also drives the transceiver power, the hold on internal RAM, and one retention control for each of the two 4 KB external RAM banks. Wake-up comes from three interrupt-pending vectors, each with its own enable mask, or from a dedicated active-low wake pin. Which of these can wake the block depends on the current mode.

Standby only stops the CPU clock. The two deeper modes power down state, so leaving either of them raises a core reset request for a fixed number of cycles. The block keeps a reset-cause field with one bit per cause. Software clears that field by writing ones to it. Analog switches, RAM macros and the interrupt controller are outside the block; it only drives and reads their ports.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: `mode_rd` shows the current mode: 0 = run, 1 = standby, 2 = sleep, 3 = deep sleep. It reads 0 again as soon as the block has come back to run. A write of 0 while in run has no effect.
- R2: A mode write is held while `mode_wr` is high. It takes effect on the first clock edge at which `mode_wr` is low, so the mode changes one cycle after the strobe falls.
- R3: In standby only `cpu_clk_en` is low. Any pending bit whose enable is set, in any of the three vectors, returns the block to run on the next edge. Pending bits whose enable is clear are ignored.
- R4: In sleep, `cpu_clk_en` and `periph_pwr_en` are low. `aon_pwr_en`, `xcvr_pwr_en` and `iram_ret` stay high.
- R5: In sleep, `xram_ret[i]` equals bit i of `xram_keep` as sampled when the sleep write took effect (1 = bank kept). Later changes to `xram_keep` have no effect. In run and standby both bits are 1.
- R6: Sleep ends only when an enabled GPIO or system-controller pending bit is present. General interrupts, even when enabled, do not end it.
- R7: Deep sleep drives every enable and retention output low. Its only exit is `wake_n` held low. This exit passes through a two-flop synchronizer, so the mode returns to run on the third edge after `wake_n` falls.
- R8: When the block leaves sleep or deep sleep, the mode returns to run and `core_rst_req` stays high for exactly RST_CYC cycles. Leaving standby never raises it.
- R9: `rst_cause` has one bit per cause: bit 0 = power-on or reset pin (set by `rst_n`), bit 1 = exit from sleep or deep sleep, bit 2 = `wdt_rst`, bit 3 = `sw_rst`. Bits accumulate. Writing `cause_wr` clears each bit where `cause_wdata` is 1. A new cause in the same cycle wins over the clear.
- R10: Mode writes are ignored unless the block is in run and `core_rst_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on / pin reset, active low |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 2 | Mode value written |
| xram_keep | input | 2 | Per-bank retain flags for sleep |
| irq_pend | input | N_IRQ | General interrupt pending |
| irq_en | input | N_IRQ | General interrupt enable |
| gpio_pend | input | N_GPIO | GPIO interrupt pending |
| gpio_en | input | N_GPIO | GPIO interrupt enable |
| sysc_pend | input | N_SYSC | System-controller interrupt pending |
| sysc_en | input | N_SYSC | System-controller interrupt enable |
| wake_n | input | 1 | Asynchronous wake pin, active low |
| wdt_rst | input | 1 | Watchdog reset event |
| sw_rst | input | 1 | Software reset event |
| cause_wr | input | 1 | Reset-cause clear strobe |
| cause_wdata | input | 4 | Write-one-to-clear mask |
| mode_rd | output | 2 | Current mode |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_pwr_en | output | 1 | General peripheral domain power |
| aon_pwr_en | output | 1 | GPIO and system-controller domain power |
| xcvr_pwr_en | output | 1 | Transceiver power |
| iram_ret | output | 1 | Internal RAM hold |
| xram_ret | output | 2 | External RAM bank retention |
| core_rst_req | output | 1 | Core reset request |
| rst_cause | output | 4 | Recorded reset causes |

## Verification
The bench builds the block with N_IRQ=6, N_GPIO=4, N_SYSC=2 and RST_CYC=3. With vectors this narrow, sparse random pending and enable patterns regularly hit only one vector, or only one enabled bit. That sorts apart the cases where a general interrupt wakes standby but not sleep. The short reset pulse lets new mode writes follow a deep-mode exit within a few cycles, so writes that arrive during the reset request and writes held across several cycles both occur often.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int N_IRQ   = 22,
  parameter int N_GPIO  = 8,
  parameter int N_SYSC  = 4,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [1:0]        mode_wdata,
  input  logic [1:0]        xram_keep,
  input  logic [N_IRQ-1:0]  irq_pend,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_GPIO-1:0] gpio_pend,
  input  logic [N_GPIO-1:0] gpio_en,
  input  logic [N_SYSC-1:0] sysc_pend,
  input  logic [N_SYSC-1:0] sysc_en,
  input  logic              wake_n,
  input  logic              wdt_rst,
  input  logic              sw_rst,
  input  logic              cause_wr,
  input  logic [3:0]        cause_wdata,
  output logic [1:0]        mode_rd,
  output logic              cpu_clk_en,
  output logic              periph_pwr_en,
  output logic              aon_pwr_en,
  output logic              xcvr_pwr_en,
  output logic              iram_ret,
  output logic [1:0]        xram_ret,
  output logic              core_rst_req,
  output logic [3:0]        rst_cause
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [1:0] M_RUN = 2'd0, M_STBY = 2'd1, M_SLP = 2'd2, M_DEEP = 2'd3;

  logic [1:0]    mode_q, pend_m, keep_q, wk_q;
  logic          pend_vld;
  logic [CW-1:0] rst_cnt;
  logic [3:0]    cause_q;

  wire aon_hit = |(gpio_pend & gpio_en) | |(sysc_pend & sysc_en);
  wire any_hit = aon_hit | |(irq_pend & irq_en);
  wire wake_lo = ~wk_q[1];
  wire accept  = (mode_q == M_RUN) && (rst_cnt == '0);
  wire lp_exit = ((mode_q == M_SLP) && aon_hit) || ((mode_q == M_DEEP) && wake_lo);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wk_q <= 2'b11;
    else        wk_q <= {wk_q[0], wake_n};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_RUN;
      pend_m   <= M_RUN;
      pend_vld <= 1'b0;
      keep_q   <= 2'b00;
      rst_cnt  <= '0;
    end else begin
      if (rst_cnt != '0) rst_cnt <= rst_cnt - 1'b1;
      case (mode_q)
        M_RUN:
          if (accept && mode_wr) begin
            pend_m   <= mode_wdata;
            pend_vld <= (mode_wdata != M_RUN);
          end else if (pend_vld) begin
            mode_q   <= pend_m;
            pend_vld <= 1'b0;
            keep_q   <= xram_keep;
          end
        M_STBY:
          if (any_hit) mode_q <= M_RUN;
        default:
          if (lp_exit) begin
            mode_q  <= M_RUN;
            rst_cnt <= CW'(RST_CYC);
          end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cause_q <= 4'b0001;
    else        cause_q <= (cause_q & ~(cause_wr ? cause_wdata : 4'h0))
                           | {sw_rst, wdt_rst, lp_exit, 1'b0};

  assign mode_rd       = mode_q;
  assign cpu_clk_en    = (mode_q == M_RUN);
  assign periph_pwr_en = ~mode_q[1];
  assign aon_pwr_en    = (mode_q != M_DEEP);
  assign xcvr_pwr_en   = (mode_q != M_DEEP);
  assign iram_ret      = (mode_q != M_DEEP);
  assign xram_ret      = (mode_q == M_SLP) ? keep_q : (mode_q == M_DEEP) ? 2'b00 : 2'b11;
  assign core_rst_req  = (rst_cnt != '0);
  assign rst_cause     = cause_q;

  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && mode_wr) |=> (mode_q == M_RUN));
  // R3
  stby_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_STBY && |(irq_pend & irq_en)) |=> (mode_q == M_RUN));
  // R6
  slp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SLP && !(|(gpio_pend & gpio_en)) && !(|(sysc_pend & sysc_en))) |=> (mode_q == M_SLP));
  // R7
  deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_DEEP && wk_q[1]) |=> (mode_q == M_DEEP));
  // R8
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_req) |-> $past(mode_q[1]) && rst_cause[1]);
  // R9
  wdt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> rst_cause[2]);
  // R10
  wr_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RUN && core_rst_req) |=> (mode_q == M_RUN));
endmodule

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
  localparam int NI = 6, NG = 4, NS = 2, RC = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, mode_wr, wake_n, wdt_rst, sw_rst, cause_wr;
  logic [1:0] mode_wdata, xram_keep;
  logic [NI-1:0] irq_pend, irq_en;
  logic [NG-1:0] gpio_pend, gpio_en;
  logic [NS-1:0] sysc_pend, sysc_en;
  logic [3:0] cause_wdata;
  logic [1:0] mode_rd, xram_ret;
  logic cpu_clk_en, periph_pwr_en, aon_pwr_en, xcvr_pwr_en, iram_ret, core_rst_req;
  logic [3:0] rst_cause;

  pwr_mode_ctrl #(.N_IRQ(NI), .N_GPIO(NG), .N_SYSC(NS), .RST_CYC(RC)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .xram_keep(xram_keep), .irq_pend(irq_pend), .irq_en(irq_en),
    .gpio_pend(gpio_pend), .gpio_en(gpio_en), .sysc_pend(sysc_pend), .sysc_en(sysc_en),
    .wake_n(wake_n), .wdt_rst(wdt_rst), .sw_rst(sw_rst), .cause_wr(cause_wr),
    .cause_wdata(cause_wdata), .mode_rd(mode_rd), .cpu_clk_en(cpu_clk_en),
    .periph_pwr_en(periph_pwr_en), .aon_pwr_en(aon_pwr_en), .xcvr_pwr_en(xcvr_pwr_en),
    .iram_ret(iram_ret), .xram_ret(xram_ret), .core_rst_req(core_rst_req),
    .rst_cause(rst_cause));

  int tests = 0, fails = 0;

  // expected state, advanced from the requirements
  logic [1:0] e_mode, e_pm, e_keep, e_s;
  logic e_pv;
  int e_cnt;
  logic [3:0] e_cause;
  wire e_aon = |(gpio_pend & gpio_en) | |(sysc_pend & sysc_en);
  wire e_any = e_aon | |(irq_pend & irq_en);
  wire e_ex  = (e_mode == 2'd2 && e_aon) || (e_mode == 2'd3 && !e_s[1]);

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      e_mode <= 0; e_pm <= 0; e_pv <= 0; e_keep <= 0; e_cnt <= 0; e_cause <= 4'b0001; e_s <= 2'b11;
    end else begin
      e_s <= {e_s[0], wake_n};
      if (e_cnt > 0) e_cnt <= e_cnt - 1;
      if (e_mode == 0) begin
        if (mode_wr && e_cnt == 0) begin e_pm <= mode_wdata; e_pv <= (mode_wdata != 0); end
        else if (e_pv) begin e_mode <= e_pm; e_pv <= 0; e_keep <= xram_keep; end
      end else if (e_mode == 1) begin
        if (e_any) e_mode <= 0;
      end else if (e_ex) begin
        e_mode <= 0; e_cnt <= RC;
      end
      e_cause <= (e_cause & ~(cause_wr ? cause_wdata : 4'h0)) | {sw_rst, wdt_rst, e_ex, 1'b0};
    end

  function automatic logic [1:0] exp_xram(logic [1:0] m, logic [1:0] k);
    return (m == 2) ? k : (m == 3) ? 2'b00 : 2'b11;
  endfunction

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 mode_rd", 8'(mode_rd), 8'(e_mode));
    chk("R3 cpu_clk_en", 8'(cpu_clk_en), 8'(e_mode == 0));
    chk("R4 periph_pwr_en", 8'(periph_pwr_en), 8'(e_mode < 2));
    chk("R7 aon_pwr_en", 8'(aon_pwr_en), 8'(e_mode != 3));
    chk("R7 xcvr_pwr_en", 8'(xcvr_pwr_en), 8'(e_mode != 3));
    chk("R4 iram_ret", 8'(iram_ret), 8'(e_mode != 3));
    chk("R5 xram_ret", 8'(xram_ret), 8'(exp_xram(e_mode, e_keep)));
    chk("R8 core_rst_req", 8'(core_rst_req), 8'(e_cnt != 0));
    chk("R9 rst_cause", 8'(rst_cause), 8'(e_cause));
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); check_all();
  endtask

  task automatic quiet();
    mode_wr = 0; irq_pend = 0; gpio_pend = 0; sysc_pend = 0;
    wake_n = 1; wdt_rst = 0; sw_rst = 0; cause_wr = 0;
  endtask

  task automatic go_mode(logic [1:0] m);
    mode_wr = 1; mode_wdata = m; step();
    mode_wr = 0; step();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; quiet(); mode_wdata = 0; xram_keep = 0; cause_wdata = 0;
    irq_en = '1; gpio_en = '1; sysc_en = '1;
    repeat (3) @(negedge clk);
    chk("R9 reset cause", 8'(rst_cause), 8'h01);
    chk("R1 reset mode", 8'(mode_rd), 8'h00);
    rst_n = 1; step();

    // R2: held strobe delays entry
    mode_wr = 1; mode_wdata = 2'd1; step(); step();
    chk("R2 still run while strobe high", 8'(mode_rd), 8'h00);
    mode_wr = 0; step();
    chk("R2 standby after strobe falls", 8'(mode_rd), 8'h01);
    // R10: write ignored in standby
    mode_wr = 1; mode_wdata = 2'd3; step(); mode_wr = 0; step();
    chk("R10 write in standby ignored", 8'(mode_rd), 8'h01);
    // R3: disabled pending ignored, enabled wakes
    irq_en = 0; irq_pend = '1; step();
    chk("R3 disabled irq ignored", 8'(mode_rd), 8'h01);
    irq_en = 1; step();
    chk("R3 enabled irq wakes", 8'(mode_rd), 8'h00);
    chk("R8 no reset from standby", 8'(core_rst_req), 8'h00);
    quiet(); irq_en = '1; step();

    // R5/R6: sleep with bank 1 kept
    xram_keep = 2'b10; go_mode(2'd2);
    xram_keep = 2'b01; step();
    chk("R5 keep latched at entry", 8'(xram_ret), 8'h02);
    irq_pend = '1; step();
    chk("R6 general irq ignored in sleep", 8'(mode_rd), 8'h02);
    irq_pend = 0; sysc_pend = 1; step();
    chk("R8 sleep exit reset", 8'(core_rst_req), 8'h01);
    chk("R1 reads run after exit", 8'(mode_rd), 8'h00);
    sysc_pend = 0;
    mode_wr = 1; mode_wdata = 2'd1; step(); mode_wr = 0; step();
    chk("R10 write during reset ignored", 8'(mode_rd), 8'h00);
    repeat (RC) step();
    chk("R8 reset pulse ended", 8'(core_rst_req), 8'h00);

    // R7: deep sleep, wake pin
    go_mode(2'd3);
    gpio_pend = '1; irq_pend = '1; step();
    chk("R7 irq ignored in deep", 8'(mode_rd), 8'h03);
    gpio_pend = 0; irq_pend = 0; wake_n = 0; step(); step();
    chk("R7 synchronizer delay", 8'(mode_rd), 8'h03);
    step();
    chk("R7 deep exit", 8'(mode_rd), 8'h00);
    wake_n = 1;
    // R9: clear with same-cycle set
    wdt_rst = 1; cause_wr = 1; cause_wdata = 4'hF; step();
    chk("R9 set wins over clear", 8'(rst_cause), 8'h04);
    quiet(); repeat (RC) step();

    // random phase
    for (int i = 0; i < 4000; i++) begin
      mode_wr    = ($urandom % 4) == 0;
      mode_wdata = 2'($urandom);
      xram_keep  = 2'($urandom);
      irq_pend   = NI'($urandom & $urandom & $urandom);
      irq_en     = NI'($urandom);
      gpio_pend  = NG'($urandom & $urandom & $urandom);
      gpio_en    = NG'($urandom);
      sysc_pend  = NS'($urandom & $urandom);
      sysc_en    = NS'($urandom);
      wake_n     = ($urandom % 8) != 0;
      wdt_rst    = ($urandom % 32) == 0;
      sw_rst     = ($urandom % 32) == 0;
      cause_wr   = ($urandom % 8) == 0;
      cause_wdata = 4'($urandom);
      step();
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule